// File: doc/BRIEF.md
# Flash Command Gate with Write-Protect Logic

This block sits between the opcode decoder and the execution engine of a serial flash device. Each decoded opcode arrives as a one-cycle strobe together with its target address. The gate answers one cycle later with either a go pulse or a deny pulse. It bases that answer on the write-enable latch it owns, the five block-protect bits, the quad-enable bit, the hardware write-protect pin and the deep power-down state. The execution engine returns a done pulse when an accepted command finishes. That pulse ends any pending write-enable clear and releases the quad pin roles.

When a quad command is accepted, the four serial pins switch to bidirectional data roles: SI to IO0, SO to IO1, the write-protect pin to IO2 and the hold pin to IO3. Those roles stay in place until the engine signals done. An accepted status-register write also records whether the protect and protect-lock fields must stay frozen. Those fields are frozen when the write-protect pin was low at acceptance.

Top module: `flash_cmd_gate`

## Requirements
- R1: Write Enable (06h), accepted outside deep power-down, sets welState from the next cycle. Write Disable (04h), when accepted, clears welState from the next cycle.
- R2: Modifying opcodes are 01h (status write), 02h, 32h, 20h, D8h, C7h, 60h, 44h and 42h. A modifying opcode is denied while welState is 0. A denial that has no protection cause leaves welState unchanged.
- R3: After an accepted modifying command, welState stays 1 until an execDone pulse arrives. welState is 0 from the cycle after that pulse.
- R4: Quad opcodes 6Bh, EBh, E7h and 32h are denied while quadEnable is 0, and welState is unchanged.
- R5: An accepted quad opcode drives every bit of quadRoles to 1 from the next cycle. Bit 0 is SI as IO0, bit 1 is SO as IO1, bit 2 is the write-protect pin as IO2 and bit 3 is the hold pin as IO3. quadRoles returns to 0 in the cycle after execDone and is 0 otherwise.
- R6: Let n = bpField[2:0]. The base region is empty for n=0 and covers the whole array for n=7. For other n, it is the 2^(ADDR_W-7+n) bytes at the top of the array when bpField[3]=0, or at the bottom when bpField[3]=1. bpField[4]=1 inverts the protected set to the complement of the base region.
- R7: Opcodes 02h, 32h, 20h and D8h are denied when their address is protected. C7h and 60h are denied when any address is protected. Either kind of denial clears welState. Security-register opcodes 44h and 42h, and all reads, ignore bpField.
- R8: While dpdActive is 1, every opcode except ABh is denied and welState is unchanged. ABh is accepted.
- R9: On an accepted 01h, srFieldLock loads 1 if wpN is 0 and 0 if wpN is 1. It holds that value until the next accepted 01h.
- R10: Every cmdValid strobe produces exactly one of execGo or execDeny, as a one-cycle pulse in the next cycle. Neither pulse appears without a strobe. Opcodes that are not modifying and not quad, such as read 03h, are accepted outside deep power-down.
- R11: If a Write Enable is accepted in the same cycle as execDone, welState is 1 afterwards, and that done pulse no longer clears it.
- R12: While rstN is low, welState, execGo, execDeny, quadRoles and srFieldLock are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Decoded opcode strobe |
| cmdOpcode | input | 8 | Decoded opcode |
| cmdAddr | input | ADDR_W | Target address of the command |
| bpField | input | 5 | Block-protect field from the status register |
| quadEnable | input | 1 | Quad-enable status bit |
| wpN | input | 1 | Hardware write-protect pin, active low |
| dpdActive | input | 1 | Device is in deep power-down |
| execDone | input | 1 | Execution engine completion pulse |
| execGo | output | 1 | Command accepted pulse |
| execDeny | output | 1 | Command rejected pulse |
| welState | output | 1 | Write-enable latch |
| quadRoles | output | QUAD_PINS | Per-pin quad bidirectional role enables |
| srFieldLock | output | 1 | Protect fields frozen for the accepted status write |

## Verification
Two functions can meet in one clock edge: a new Write Enable that sets the latch, and the done pulse of an earlier program that clears it. The bench accepts a program first. It then raises cmdValid with opcode 06h and execDone on the same negative edge. It expects welState to be 1 after that edge. A later done pulse on its own must leave the latch set. The bench also runs the opposite pairing, where a read strobe coincides with the done pulse, and expects the latch to drop.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_WAKE  = 8'hAB;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_PP    = 8'h02;
  localparam logic [7:0] OP_QPP   = 8'h32;
  localparam logic [7:0] OP_SE    = 8'h20;
  localparam logic [7:0] OP_BE    = 8'hD8;
  localparam logic [7:0] OP_CE_A  = 8'hC7;
  localparam logic [7:0] OP_CE_B  = 8'h60;
  localparam logic [7:0] OP_SECER = 8'h44;
  localparam logic [7:0] OP_SECPG = 8'h42;
  localparam logic [7:0] OP_QRD_A = 8'h6B;
  localparam logic [7:0] OP_QRD_B = 8'hEB;
  localparam logic [7:0] OP_QRD_C = 8'hE7;

  // strobes from the control half to the register half
  typedef struct packed {
    logic accept;
    logic deny;
    logic setWel;
    logic clrWel;
    logic armClear;
    logic quadStart;
    logic lockLoad;
    logic lockVal;
  } gateStbT;

  function automatic logic isModifyOp(input logic [7:0] op);
    return op inside {OP_WRSR, OP_PP, OP_QPP, OP_SE, OP_BE, OP_CE_A, OP_CE_B,
                      OP_SECER, OP_SECPG};
  endfunction

  function automatic logic isQuadOp(input logic [7:0] op);
    return op inside {OP_QRD_A, OP_QRD_B, OP_QRD_C, OP_QPP};
  endfunction

  function automatic logic isAddrWriteOp(input logic [7:0] op);
    return op inside {OP_PP, OP_QPP, OP_SE, OP_BE};
  endfunction

  function automatic logic isChipEraseOp(input logic [7:0] op);
    return op inside {OP_CE_A, OP_CE_B};
  endfunction
endpackage

// File: rtl/fcg_prot_cmp.sv
module fcg_prot_cmp #(
  parameter int ADDR_W = 18
) (
  input  logic [4:0]        bpField,
  input  logic [ADDR_W-1:0] addr,
  output logic              addrHit,
  output logic              anyHit
);
  localparam int BASE_SH = ADDR_W - 7;
  localparam logic [ADDR_W:0] TOTAL = (ADDR_W+1)'(1) << ADDR_W;

  logic [2:0]      sizeSel;
  logic [ADDR_W:0] regionSize;
  logic [ADDR_W:0] wideAddr;
  logic            inBase;

  assign sizeSel    = bpField[2:0];
  assign regionSize = (ADDR_W+1)'(1) << (BASE_SH + int'(sizeSel));
  assign wideAddr   = {1'b0, addr};

  always_comb begin
    if (sizeSel == 3'd0)      inBase = 1'b0;
    else if (sizeSel == 3'd7) inBase = 1'b1;
    else if (bpField[3])      inBase = wideAddr < regionSize;
    else                      inBase = wideAddr >= (TOTAL - regionSize);
  end

  assign addrHit = inBase ^ bpField[4];
  assign anyHit  = !(((sizeSel == 3'd0) && !bpField[4]) ||
                     ((sizeSel == 3'd7) &&  bpField[4]));
endmodule

// File: rtl/fcg_ctrl.sv
module fcg_ctrl
  import fcg_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              cmdValid,
  input  logic [7:0]        cmdOpcode,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [4:0]        bpField,
  input  logic              quadEnable,
  input  logic              wpN,
  input  logic              dpdActive,
  input  logic              welNow,
  output gateStbT           gateStb
);
  logic addrHit, anyHit, protHit;
  logic pass, protDeny;

  fcg_prot_cmp #(.ADDR_W(ADDR_W)) prot_i (
    .bpField (bpField),
    .addr    (cmdAddr),
    .addrHit (addrHit),
    .anyHit  (anyHit)
  );

  assign protHit = (isAddrWriteOp(cmdOpcode) && addrHit) ||
                   (isChipEraseOp(cmdOpcode) && anyHit);

  // ordered decision: power state, quad enable, latch, protection
  always_comb begin
    pass     = 1'b1;
    protDeny = 1'b0;
    if (dpdActive)                                 pass = (cmdOpcode == OP_WAKE);
    else if (isQuadOp(cmdOpcode) && !quadEnable)   pass = 1'b0;
    else if (isModifyOp(cmdOpcode) && !welNow)     pass = 1'b0;
    else if (protHit) begin
      pass     = 1'b0;
      protDeny = 1'b1;
    end
  end

  always_comb begin
    gateStb           = '0;
    gateStb.accept    = cmdValid && pass;
    gateStb.deny      = cmdValid && !pass;
    gateStb.setWel    = gateStb.accept && (cmdOpcode == OP_WREN);
    gateStb.clrWel    = (gateStb.accept && (cmdOpcode == OP_WRDI)) ||
                        (gateStb.deny && protDeny);
    gateStb.armClear  = gateStb.accept && isModifyOp(cmdOpcode);
    gateStb.quadStart = gateStb.accept && isQuadOp(cmdOpcode);
    gateStb.lockLoad  = gateStb.accept && (cmdOpcode == OP_WRSR);
    gateStb.lockVal   = !wpN;
  end
endmodule

// File: rtl/fcg_datapath.sv
module fcg_datapath
  import fcg_pkg::*;
#(
  parameter int QUAD_PINS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gateStbT              gateStb,
  input  logic                 execDone,
  output logic                 execGo,
  output logic                 execDeny,
  output logic                 welState,
  output logic [QUAD_PINS-1:0] quadRoles,
  output logic                 srFieldLock
);
  logic welQ, pendQ, quadQ, lockQ, goQ, denyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      welQ  <= 1'b0;
      pendQ <= 1'b0;
      quadQ <= 1'b0;
      lockQ <= 1'b0;
      goQ   <= 1'b0;
      denyQ <= 1'b0;
    end else begin
      goQ   <= gateStb.accept;
      denyQ <= gateStb.deny;
      if (gateStb.setWel)              welQ <= 1'b1;
      else if (gateStb.clrWel)         welQ <= 1'b0;
      else if (execDone && pendQ)      welQ <= 1'b0;
      if (gateStb.armClear)            pendQ <= 1'b1;
      else if (execDone || gateStb.setWel) pendQ <= 1'b0;
      if (gateStb.quadStart)           quadQ <= 1'b1;
      else if (execDone)               quadQ <= 1'b0;
      if (gateStb.lockLoad)            lockQ <= gateStb.lockVal;
    end
  end

  for (genvar p = 0; p < QUAD_PINS; p++) begin : g_pinRole
    assign quadRoles[p] = quadQ;
  end

  assign execGo      = goQ;
  assign execDeny    = denyQ;
  assign welState    = welQ;
  assign srFieldLock = lockQ;

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(execGo && execDeny));

  // R3
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    execDone && pendQ && !gateStb.setWel && !gateStb.armClear |=> !welState);

  // R11
  wel_win_chk: assert property (@(posedge clk) disable iff (!rstN)
    gateStb.setWel |=> welState && !pendQ);
endmodule

// File: rtl/flash_cmd_gate.sv
module flash_cmd_gate
  import fcg_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int QUAD_PINS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [7:0]           cmdOpcode,
  input  logic [ADDR_W-1:0]    cmdAddr,
  input  logic [4:0]           bpField,
  input  logic                 quadEnable,
  input  logic                 wpN,
  input  logic                 dpdActive,
  input  logic                 execDone,
  output logic                 execGo,
  output logic                 execDeny,
  output logic                 welState,
  output logic [QUAD_PINS-1:0] quadRoles,
  output logic                 srFieldLock
);
  gateStbT gateStb;

  fcg_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .cmdValid   (cmdValid),
    .cmdOpcode  (cmdOpcode),
    .cmdAddr    (cmdAddr),
    .bpField    (bpField),
    .quadEnable (quadEnable),
    .wpN        (wpN),
    .dpdActive  (dpdActive),
    .welNow     (welState),
    .gateStb    (gateStb)
  );

  fcg_datapath #(.QUAD_PINS(QUAD_PINS)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .gateStb     (gateStb),
    .execDone    (execDone),
    .execGo      (execGo),
    .execDeny    (execDeny),
    .welState    (welState),
    .quadRoles   (quadRoles),
    .srFieldLock (srFieldLock)
  );

  // R1
  wren_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && (cmdOpcode == OP_WREN) && !dpdActive |=> welState && execGo);

  // R2
  wel_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !welState && isModifyOp(cmdOpcode) |=> execDeny);

  // R4
  quad_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !quadEnable && isQuadOp(cmdOpcode) |=> execDeny);

  // R8
  dpd_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && dpdActive && (cmdOpcode != OP_WAKE) |=> execDeny && $stable(welState));

  // R10
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> !execGo && !execDeny);
endmodule

// File: tb/flash_cmd_gate_tb_top.sv
module flash_cmd_gate_tb_top;
  localparam int AW = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [7:0] cmdOpcode = '0;
  logic [AW-1:0] cmdAddr = '0;
  logic [4:0] bpField = '0;
  logic quadEnable = 1'b0;
  logic wpN = 1'b1;
  logic dpdActive = 1'b0;
  logic execDone = 1'b0;
  logic execGo, execDeny, welState, srFieldLock;
  logic [3:0] quadRoles;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_cmd_gate #(.ADDR_W(AW), .QUAD_PINS(4)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOpcode(cmdOpcode),
    .cmdAddr(cmdAddr), .bpField(bpField), .quadEnable(quadEnable), .wpN(wpN),
    .dpdActive(dpdActive), .execDone(execDone), .execGo(execGo),
    .execDeny(execDeny), .welState(welState), .quadRoles(quadRoles),
    .srFieldLock(srFieldLock)
  );

  typedef struct packed {
    logic [7:0]    op;
    logic [AW-1:0] addr;
    logic [4:0]    bp;
    logic          qe;
    logic          dpd;
    logic          done;
    logic          expGo;
    logic          expWel;
    logic          expQuad;
  } vecT;

  localparam int NV = 36;
  localparam vecT VECS [NV] = '{
    '{8'h02, 18'h00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 no latch
    '{8'h06, 18'h00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R1
    '{8'h6B, 18'h00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4
    '{8'h6B, 18'h00000, 5'b00000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R5
    '{8'h02, 18'h3F800, 5'b00001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 top hit
    '{8'h06, 18'h00000, 5'b00001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'h02, 18'h3EFFF, 5'b00001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R3 R6
    '{8'h03, 18'h3F800, 5'b00001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R10 read
    '{8'h06, 18'h00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'h20, 18'h00800, 5'b01001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 bottom
    '{8'h06, 18'h00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'h20, 18'h3F800, 5'b01001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    '{8'h06, 18'h00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'hC7, 18'h00000, 5'b00001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 chip
    '{8'h06, 18'h00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'h60, 18'h00000, 5'b00000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    '{8'h06, 18'h00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'h02, 18'h00000, 5'b10001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 complement
    '{8'h06, 18'h00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'h02, 18'h3F000, 5'b10001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    '{8'h06, 18'h00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'hD8, 18'h12345, 5'b00111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 all
    '{8'h06, 18'h00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'h44, 18'h00000, 5'b00111, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R7 security
    '{8'h06, 18'h00000, 5'b00000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8
    '{8'h03, 18'h00000, 5'b00000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8
    '{8'hAB, 18'h00000, 5'b00000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 wake
    '{8'h06, 18'h00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'h32, 18'h00000, 5'b00000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R5 quad program
    '{8'h06, 18'h00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'h04, 18'h00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R1 disable
    '{8'h32, 18'h00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4
    '{8'h06, 18'h00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'h02, 18'h04000, 5'b01011, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R6 edge out
    '{8'h06, 18'h00000, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'h02, 18'h03FFF, 5'b01011, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}  // R6 edge in
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [AW-1:0] addr);
    cmdOpcode = op;
    cmdAddr   = addr;
    cmdValid  = 1'b1;
    @(negedge clk);
    cmdValid  = 1'b0;
  endtask

  task automatic pulseDone();
    execDone = 1'b1;
    @(negedge clk);
    execDone = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 wel in reset", welState, 0);
    chk("R12 go/deny in reset", {execGo, execDeny}, 0);
    chk("R12 quad in reset", quadRoles, 0);
    chk("R12 lock in reset", srFieldLock, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      bpField    = VECS[i].bp;
      quadEnable = VECS[i].qe;
      dpdActive  = VECS[i].dpd;
      issue(VECS[i].op, VECS[i].addr);
      chk($sformatf("R10 go vec%0d", i), execGo, VECS[i].expGo);
      chk($sformatf("R10 deny vec%0d", i), execDeny, !VECS[i].expGo);
      chk($sformatf("R1/R2/R3/R7/R8 wel vec%0d", i), welState, VECS[i].expWel);
      chk($sformatf("R5 quad vec%0d", i), quadRoles, VECS[i].expQuad ? 4'hF : 4'h0);
      if (VECS[i].done) pulseDone();
      else @(negedge clk);
      chk($sformatf("R10 idle vec%0d", i), {execGo, execDeny}, 0);
    end
    dpdActive = 1'b0;
    quadEnable = 1'b0;
    bpField = '0;

    // R5 roles released after done
    chk("R5 quad released", quadRoles, 0);

    // R11 enable and done in the same cycle
    issue(8'h06, '0);
    issue(8'h02, '0);
    chk("R3 pending wel", welState, 1);
    cmdOpcode = 8'h06; cmdValid = 1'b1; execDone = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0; execDone = 1'b0;
    chk("R11 set beats done", welState, 1);
    pulseDone();
    chk("R11 stale done ignored", welState, 1);

    // R3 done coinciding with a read strobe
    issue(8'h02, '0);
    cmdOpcode = 8'h03; cmdValid = 1'b1; execDone = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0; execDone = 1'b0;
    chk("R3 done with read clears", welState, 0);
    chk("R10 read accepted", execGo, 1);

    // R9 status write under the write-protect pin
    issue(8'h06, '0);
    wpN = 1'b0;
    issue(8'h01, '0);
    chk("R9 status write accepted", execGo, 1);
    chk("R9 lock set", srFieldLock, 1);
    pulseDone();
    chk("R9 wel cleared by status write", welState, 0);
    wpN = 1'b1;
    issue(8'h01, '0);
    chk("R9 lock held on denied write", srFieldLock, 1);
    issue(8'h06, '0);
    issue(8'h01, '0);
    chk("R9 lock released", srFieldLock, 0);
    pulseDone();

    // R12 reset mid-run
    issue(8'h06, '0);
    chk("R1 wel before reset", welState, 1);
    rstN = 1'b0;
    @(negedge clk);
    chk("R12 wel after reset", welState, 0);
    rstN = 1'b1;
    @(negedge clk);
    report();
  end
endmodule